// File: doc/BRIEF.md
# Dual Comparator Control and Change-Interrupt Register

This block is the digital side of a pair of analog voltage comparators on a small microcontroller peripheral bus. Each comparator owns one byte-wide control register. Software uses it to switch the comparator on, to steer two input multiplexers, and to route the result to an output pin. Software can also read back a clock-synchronized copy of the comparison result and a sticky flag that records any change of that result.

The analog decision arrives as a raw, asynchronous digital input for each comparator. The block passes it through a two-stage synchronizer and tracks its previous value so that every change, in either direction, latches the flag. While a comparator settles after being switched on, its synchronized output reads 0 and its flag cannot be set. The pin output carries the raw result directly and is forced low unless the comparator is both enabled and pin-enabled. Each flag is gated with its own interrupt-enable input, and the two gated requests are ORed onto one interrupt line.

Top module: `cmpx_top`

## Requirements
- R1: Comparator 0 is addressed at 0xAC and comparator 1 at 0xAD. A write to any other address changes neither register, and a read of any other address returns 0x00.
- R2: The register reads as {2'b00, EN[5], PSEL[4], NSEL[3], OE[2], CO[1], FLAG[0]}. Bits 7, 6 and 1 ignore writes, and bits 7 and 6 read 0.
- R3: Output `pos_sel[i]` equals register bit 4 (0 picks input A, 1 picks input B). Output `neg_sel[i]` equals bit 3 (0 picks the external reference pin, 1 picks the internal reference).
- R4: `cmp_pin[i]` equals the raw input `cmp_raw[i]` without any clock delay when EN=1 and OE=1. Otherwise it is 0.
- R5: When the comparator is enabled and settled, CO follows `cmp_raw[i]` two clock edges after the input changes. While EN=0, CO reads 0.
- R6: FLAG becomes 1 on the clock edge after CO changes, for both 0-to-1 and 1-to-0 changes.
- R7: Writing 0 to bit 0 clears FLAG, and writing 1 to bit 0 leaves it unchanged. When a hardware set and a software clear fall on the same edge, FLAG ends at 1.
- R8: After a write that takes EN from 0 to 1, CO reads 0 and FLAG cannot be set for SETTLE_CYCLES clock edges. If the input is steady across the end of that window, FLAG stays 0.
- R9: `irq` is 1 exactly when, for some comparator, both FLAG and `irq_en[i]` are 1.
- R10: After reset, every register bit and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cmp_raw | input | 2 | Raw asynchronous comparator results |
| irq_en | input | 2 | Per-comparator interrupt enable |
| pos_sel | output | 2 | Positive-input mux select |
| neg_sel | output | 2 | Negative-input mux select |
| cmp_pin | output | 2 | Gated raw result for the output pins |
| irq | output | 1 | Merged interrupt request |

## Verification
A register write takes effect on the edge that samples it. A new raw value appears in CO after the second edge and in FLAG after the third. The pin and `irq` respond within the same cycle. The bench drives every input just after a falling edge and samples just before the next rising edge or after a one-nanosecond combinational delay, so each check lands exactly on the cycle the requirements name. The configuration field is swept exhaustively on both comparators. The settling window is walked edge by edge with a short SETTLE_CYCLES, including an input that toggles inside the window.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_EN   = 5;
    localparam int BIT_PSEL = 4;
    localparam int BIT_NSEL = 3;
    localparam int BIT_OE   = 2;
    localparam int BIT_CO   = 1;
    localparam int BIT_FLAG = 0;

    typedef struct packed {
        logic en;
        logic psel;
        logic nsel;
        logic oe;
    } cmp_cfg_t;

    typedef struct packed {
        logic co;
        logic flag;
    } cmp_stat_t;

    function automatic cmp_cfg_t cfg_from_byte(input logic [REG_W-1:0] b);
        cmp_cfg_t c;
        c.en   = b[BIT_EN];
        c.psel = b[BIT_PSEL];
        c.nsel = b[BIT_NSEL];
        c.oe   = b[BIT_OE];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] reg_image(input cmp_cfg_t c, input cmp_stat_t s);
        logic [REG_W-1:0] r;
        r           = '0;
        r[BIT_EN]   = c.en;
        r[BIT_PSEL] = c.psel;
        r[BIT_NSEL] = c.nsel;
        r[BIT_OE]   = c.oe;
        r[BIT_CO]   = s.co;
        r[BIT_FLAG] = s.flag;
        return r;
    endfunction
endpackage

// File: rtl/cmpx_sync.sv
module cmpx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpx_settle.sv
module cmpx_settle #(
    parameter int CYCLES = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    output logic settled
);
    localparam int CW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (stop)           cnt <= '0;
        else if (start)          cnt <= LOAD;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign settled = (cnt == '0);
endmodule

// File: rtl/cmpx_channel.sv
module cmpx_channel
    import cmpx_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1250,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             raw,
    output cmp_cfg_t         cfg,
    output cmp_stat_t        stat,
    output logic             settled,
    output logic             pin
);
    cmp_cfg_t cfg_q;
    logic     sync_q;
    logic     prev_q;
    logic     flag_q;
    logic     live;
    logic     change;
    logic     start;
    logic     stop;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (sel_wr) cfg_q <= cfg_from_byte(wdata);
    end

    assign start = sel_wr &  wdata[BIT_EN] & ~cfg_q.en;
    assign stop  = sel_wr & ~wdata[BIT_EN];

    cmpx_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .stop    (stop),
        .settled (settled)
    );

    cmpx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (sync_q)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q;
    end

    assign live   = cfg_q.en & settled;
    assign change = live & (sync_q != prev_q);

    always_ff @(posedge clk) begin
        if (rst)                          flag_q <= 1'b0;
        else if (change)                  flag_q <= 1'b1;
        else if (sel_wr & ~wdata[BIT_FLAG]) flag_q <= 1'b0;
    end

    assign cfg       = cfg_q;
    assign stat.co   = live & sync_q;
    assign stat.flag = flag_q;
    assign pin       = raw & cfg_q.en & cfg_q.oe;
endmodule

// File: rtl/cmpx_top.sv
module cmpx_top
    import cmpx_pkg::*;
#(
    parameter int          NUM_CMP       = 2,
    parameter int          ADDR_W        = 8,
    parameter logic [7:0]  BASE_ADDR     = 8'hAC,
    parameter int          SETTLE_CYCLES = 1250,
    parameter int          SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_CMP-1:0] cmp_raw,
    input  logic [NUM_CMP-1:0] irq_en,
    output logic [NUM_CMP-1:0] pos_sel,
    output logic [NUM_CMP-1:0] neg_sel,
    output logic [NUM_CMP-1:0] cmp_pin,
    output logic               irq
);
    logic [NUM_CMP-1:0] bus_hit;
    logic [NUM_CMP-1:0] ch_en;
    logic [NUM_CMP-1:0] ch_oe;
    logic [NUM_CMP-1:0] ch_co;
    logic [NUM_CMP-1:0] ch_flag;
    logic [NUM_CMP-1:0] ch_settled;
    logic [REG_W-1:0]   ch_image [NUM_CMP];

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
        cmp_cfg_t  cfg;
        cmp_stat_t stat;

        assign bus_hit[i] = (bus_addr == ADDR_W'(BASE_ADDR + i));

        cmpx_channel #(
            .SETTLE_CYCLES (SETTLE_CYCLES),
            .SYNC_STAGES   (SYNC_STAGES)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .sel_wr  (bus_wr & bus_hit[i]),
            .wdata   (bus_wdata),
            .raw     (cmp_raw[i]),
            .cfg     (cfg),
            .stat    (stat),
            .settled (ch_settled[i]),
            .pin     (cmp_pin[i])
        );

        assign ch_en[i]    = cfg.en;
        assign ch_oe[i]    = cfg.oe;
        assign ch_co[i]    = stat.co;
        assign ch_flag[i]  = stat.flag;
        assign pos_sel[i]  = cfg.psel;
        assign neg_sel[i]  = cfg.nsel;
        assign ch_image[i] = reg_image(cfg, stat);
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CMP; i++) begin
            if (bus_hit[i]) bus_rdata = bus_rdata | ch_image[i];
        end
    end

    assign irq = |(ch_flag & irq_en);
endmodule

// File: rtl/cmpx_checker.sv
module cmpx_checker #(
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_wr,
    input logic [7:0]   bus_wdata,
    input logic [N-1:0] bus_hit,
    input logic [N-1:0] ch_en,
    input logic [N-1:0] ch_oe,
    input logic [N-1:0] ch_co,
    input logic [N-1:0] ch_flag,
    input logic [N-1:0] ch_settled,
    input logic [N-1:0] cmp_pin,
    input logic [N-1:0] irq_en,
    input logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r4_pin_low_when_gated: assert property (@(posedge clk) disable iff (rst)
            !(ch_en[i] && ch_oe[i]) |-> !cmp_pin[i]);

        a_r6_change_sets_flag: assert property (@(posedge clk) disable iff (rst)
            (ch_en[i] && ch_settled[i] && $past(ch_en[i] && ch_settled[i])
             && (ch_co[i] != $past(ch_co[i]))) |=> ch_flag[i]);

        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            (ch_flag[i] && !(bus_wr && bus_hit[i] && !bus_wdata[0])) |=> ch_flag[i]);

        a_r8_no_set_while_settling: assert property (@(posedge clk) disable iff (rst)
            !ch_settled[i] |=> !$rose(ch_flag[i]));
    end

    a_r9_irq_raised: assert property (@(posedge clk) disable iff (rst)
        ((ch_flag & irq_en) != '0) |-> irq);

    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        ((ch_flag & irq_en) == '0) |-> !irq);
endmodule

bind cmpx_top cmpx_checker #(.N(NUM_CMP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_hit    (bus_hit),
    .ch_en      (ch_en),
    .ch_oe      (ch_oe),
    .ch_co      (ch_co),
    .ch_flag    (ch_flag),
    .ch_settled (ch_settled),
    .cmp_pin    (cmp_pin),
    .irq_en     (irq_en),
    .irq        (irq)
);

// File: tb/cmpx_top_bench.sv
module cmpx_top_bench;
    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cmp_raw = '0;
    logic [1:0] irq_en = '0;
    logic [1:0] pos_sel;
    logic [1:0] neg_sel;
    logic [1:0] cmp_pin;
    logic       irq;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmpx_top #(.SETTLE_CYCLES(SETTLE)) u_cmpx_top (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmp_raw   (cmp_raw),
        .irq_en    (irq_en),
        .pos_sel   (pos_sel),
        .neg_sel   (neg_sel),
        .cmp_pin   (cmp_pin),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R10 reset state
        bus_read(8'hAC, rd); chk("R10 reg0", rd, 8'h00);
        bus_read(8'hAD, rd); chk("R10 reg1", rd, 8'h00);
        chk("R10 outputs", {pos_sel, neg_sel, cmp_pin, irq}, 7'd0);

        // R2 R3 R4 exhaustive field sweep with junk in bits 7,6,1
        for (int ch = 0; ch < 2; ch++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] fv;
                fv = 4'(f);
                bus_write(8'hAC + 8'(ch), {2'b11, fv, 2'b11});
                bus_read(8'hAC + 8'(ch), rd);
                chk("R2 readback", rd, {2'b00, fv, 2'b00});
                chk("R3 pos_sel", pos_sel[ch], fv[2]);
                chk("R3 neg_sel", neg_sel[ch], fv[1]);
                cmp_raw[ch] = 1'b1; #1;
                chk("R4 pin raw=1", cmp_pin[ch], fv[3] & fv[0]);
                cmp_raw[ch] = 1'b0; #1;
                chk("R4 pin raw=0", cmp_pin[ch], 1'b0);
            end
        end

        // R1 decoding and isolation
        bus_read(8'hAC, rd); chk("R1 reg0 kept", rd, 8'h3C);
        bus_write(8'hAB, 8'h00);
        bus_write(8'hAE, 8'h00);
        bus_read(8'hAC, rd); chk("R1 reg0 after stray", rd, 8'h3C);
        bus_read(8'hAD, rd); chk("R1 reg1 after stray", rd, 8'h3C);
        bus_read(8'hAE, rd); chk("R1 unmapped read", rd, 8'h00);
        bus_write(8'hAC, 8'h00);
        bus_write(8'hAD, 8'h00);

        // R5 R6 latency
        bus_write(8'hAC, 8'h20);
        repeat (SETTLE + 2) tick();
        cmp_raw[0] = 1'b1;
        tick(); bus_read(8'hAC, rd); chk("R5 co after 1 edge", rd[1:0], 2'b00);
        tick(); bus_read(8'hAC, rd); chk("R5 co after 2 edges", rd[1:0], 2'b10);
        tick(); bus_read(8'hAC, rd); chk("R6 rise flag", rd[1:0], 2'b11);

        // R9 interrupt gating
        #1; chk("R9 irq masked", irq, 1'b0);
        irq_en = 2'b01; #1; chk("R9 irq raised", irq, 1'b1);

        // R7 write 1 keeps, write 0 clears
        bus_write(8'hAC, 8'h21);
        bus_read(8'hAC, rd); chk("R7 write1 keeps", rd[0], 1'b1);
        bus_write(8'hAC, 8'h20);
        bus_read(8'hAC, rd); chk("R7 write0 clears", rd[0], 1'b0);
        chk("R9 irq drops", irq, 1'b0);

        // R6 falling change
        cmp_raw[0] = 1'b0;
        repeat (3) tick();
        bus_read(8'hAC, rd); chk("R6 fall flag", rd[1:0], 2'b01);
        bus_write(8'hAC, 8'h20);

        // R7 set wins over same-edge clear
        cmp_raw[0] = 1'b1;
        tick(); tick();
        bus_write(8'hAC, 8'h20);
        bus_read(8'hAC, rd); chk("R7 set wins", rd[1:0], 2'b11);
        bus_write(8'hAC, 8'h20);
        bus_read(8'hAC, rd); chk("R7 cleared", rd[0], 1'b0);

        // R5 disabled reads 0
        bus_write(8'hAC, 8'h00);
        bus_read(8'hAC, rd); chk("R5 co disabled", rd[1], 1'b0);

        // R8 settle window, steady input
        repeat (3) tick();
        bus_write(8'hAC, 8'h20);
        bus_read(8'hAC, rd); chk("R8 co k0", rd[1:0], 2'b00);
        for (int k = 1; k < SETTLE; k++) begin
            tick();
            bus_read(8'hAC, rd); chk("R8 co within window", rd[1:0], 2'b00);
        end
        tick();
        bus_read(8'hAC, rd); chk("R8 co at window end", rd[1:0], 2'b10);

        // R8 toggle inside window
        bus_write(8'hAC, 8'h00);
        bus_write(8'hAC, 8'h20);
        cmp_raw[0] = 1'b0;
        tick();
        cmp_raw[0] = 1'b1;
        tick(); tick(); tick();
        bus_read(8'hAC, rd); chk("R8 toggle suppressed", rd[1:0], 2'b10);
        repeat (2) tick();
        bus_read(8'hAC, rd); chk("R8 still quiet", rd[0], 1'b0);

        // R9 second comparator
        bus_write(8'hAD, 8'h20);
        repeat (SETTLE + 1) tick();
        cmp_raw[1] = 1'b1;
        repeat (3) tick();
        bus_read(8'hAD, rd); chk("R6 ch1 flag", rd[1:0], 2'b11);
        irq_en = 2'b01; #1; chk("R9 ch1 masked", irq, 1'b0);
        irq_en = 2'b10; #1; chk("R9 ch1 raised", irq, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule